// File: doc/BRIEF.md
# Security Violation Capture Register

This block sits beside the address-channel checks of a memory protection checker on the slave side of an AXI fabric. Each cycle it may see a read-side violation strobe, a write-side violation strobe, or both, each with the transaction ID and protection bit 1 (the non-secure indicator) of the offending transaction. The first violation seen while the interrupt status is low raises the interrupt status. It also freezes a 32-bit information word that records the offending transaction's security attribute, direction and ID, and whether a read and a write violation arrived together.

Later violations leave the frozen details unchanged and only set a "further violations" flag. A single-cycle clear pulse drops the interrupt status and wipes the word, ready for the next capture. Software reads the word through a small request/response port that uses valid/ready on both sides. Only a secure request sees the contents. A non-secure request is answered with zero.

Request/response rules: a request is accepted on a clock edge where `rq_valid` and `rq_ready` are both high. The response appears one cycle later on `rs_valid`/`rs_data`. It holds unchanged until `rs_ready` is high on an edge. `rq_ready` is low only while a response is pending and is not being taken in that cycle.

Top module: `secviol_capture`

## Requirements
- R1: After reset, `irq_status` is 0, `rs_valid` is 0, `rq_ready` is 1 and a secure read returns 0x00000000.
- R2: A read violation while `irq_status` is 0 sets `irq_status` at the next edge. The word then holds bit 16 = 0 (read), bits 15:0 = the read ID, and bit 31 = the read's protection bit 1 (1 = non-secure, 0 = secure).
- R3: A write violation while `irq_status` is 0 captures bit 16 = 1 (write), bits 15:0 = the write ID, and bit 31 = the write's protection bit 1.
- R4: ID bits at or above ID_W read as zero, and bits 30:25, 23:21 and 19:17 always read as zero.
- R5: A read and a write violation in the same capturing cycle set bit 20 and capture the write side's ID, protection bit and direction, so bit 16 = 1. A capture from a single violation leaves bit 20 at 0.
- R6: A violation while `irq_status` is 1 sets bit 24 and leaves every other bit of the word unchanged. Bit 24 stays 0 when no such violation occurs.
- R7: A high `irq_clear` returns `irq_status` and the whole word to zero at the next edge.
- R8: A violation in the same cycle as `irq_clear` is captured as a new first violation, with bit 24 = 0.
- R9: A request with `rq_nonsec` = 0 returns the current word. A request with `rq_nonsec` = 1 returns zero and changes no captured state.
- R10: A pending response keeps `rs_valid` high and `rs_data` stable while `rs_ready` is low, and `rq_ready` is low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_viol | input | 1 | Read address violation strobe |
| rd_id | input | ID_W | Read transaction ID |
| rd_nonsec | input | 1 | Read protection bit 1 (1 = non-secure) |
| wr_viol | input | 1 | Write address violation strobe |
| wr_id | input | ID_W | Write transaction ID |
| wr_nonsec | input | 1 | Write protection bit 1 (1 = non-secure) |
| irq_clear | input | 1 | Single-cycle interrupt clear |
| irq_status | output | 1 | Interrupt status |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request ready |
| rq_nonsec | input | 1 | Request is non-secure |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response ready |
| rs_data | output | 32 | Response data |

## Verification
Single-sided captures are swept over every ID value and both protection bit values, in both directions. This separates read-side from write-side field routing and confirms that the ID is zero-extended. Coincident strobes with different IDs and protection bits show which side wins and that bit 20 is set. Follow-on violations after a capture show the freeze and the bit 24 flag. A clear together with a new violation shows that the clear cannot lose an event. Non-secure reads interleaved with secure reads, and a stalled response, show the read port's masking and back-pressure.

// File: rtl/secviol_pkg.sv
package secviol_pkg;
  localparam int INFO_W = 32;
  localparam int TAG_W  = 16;

  typedef struct packed {
    logic             nonsec;
    logic             multi;
    logic             both;
    logic             is_wr;
    logic [TAG_W-1:0] tag;
  } capt_t;

  function automatic logic [INFO_W-1:0] pack_info(capt_t c);
    return {c.nonsec, 6'b0, c.multi, 3'b0, c.both, 3'b0, c.is_wr, c.tag};
  endfunction
endpackage

// File: rtl/secviol_select.sv
module secviol_select
  import secviol_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            rd_hit,
  input  logic [ID_W-1:0] rd_tag,
  input  logic            rd_ns,
  input  logic            wr_hit,
  input  logic [ID_W-1:0] wr_tag,
  input  logic            wr_ns,
  output logic            any_hit,
  output capt_t           pick
);
  localparam int PAD_W = (ID_W < TAG_W) ? (TAG_W - ID_W) : 0;

  logic [ID_W-1:0]  win_tag;
  logic [TAG_W-1:0] ext_tag;

  // the write side takes priority when both strobes are high
  assign win_tag = wr_hit ? wr_tag : rd_tag;

  generate
    if (ID_W < TAG_W) begin : g_pad
      assign ext_tag = {{PAD_W{1'b0}}, win_tag};
    end else begin : g_cut
      assign ext_tag = win_tag[TAG_W-1:0];
    end
  endgenerate

  always_comb begin
    any_hit     = rd_hit | wr_hit;
    pick.nonsec = wr_hit ? wr_ns : rd_ns;
    pick.multi  = 1'b0;
    pick.both   = rd_hit & wr_hit;
    pick.is_wr  = wr_hit;
    pick.tag    = ext_tag;
  end
endmodule

// File: rtl/secviol_state.sv
module secviol_state
  import secviol_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  any_hit,
  input  capt_t pick,
  output logic  pending,
  output capt_t held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      held    <= '0;
    end else if (clr || !pending) begin
      // a clear re-arms capture in the same cycle
      if (any_hit) begin
        pending <= 1'b1;
        held    <= pick;
      end else begin
        pending <= 1'b0;
        held    <= '0;
      end
    end else if (any_hit) begin
      held.multi <= 1'b1;
    end
  end
endmodule

// File: rtl/secviol_rdport.sv
module secviol_rdport
  import secviol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic              rq_nonsec,
  input  logic [INFO_W-1:0] word,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [INFO_W-1:0] rs_data
);
  logic take;

  assign rq_ready = !rs_valid || rs_ready;
  assign take     = rq_valid && rq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_data  <= '0;
    end else if (take) begin
      rs_valid <= 1'b1;
      rs_data  <= rq_nonsec ? '0 : word;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/secviol_capture.sv
module secviol_capture
  import secviol_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_viol,
  input  logic [ID_W-1:0] rd_id,
  input  logic            rd_nonsec,
  input  logic            wr_viol,
  input  logic [ID_W-1:0] wr_id,
  input  logic            wr_nonsec,
  input  logic            irq_clear,
  output logic            irq_status,
  input  logic            rq_valid,
  output logic            rq_ready,
  input  logic            rq_nonsec,
  output logic            rs_valid,
  input  logic            rs_ready,
  output logic [31:0]     rs_data
);
  logic              any_hit;
  capt_t             pick;
  capt_t             held;
  logic [INFO_W-1:0] info_word;

  secviol_select #(.ID_W(ID_W)) u_sel (
    .rd_hit (rd_viol),
    .rd_tag (rd_id),
    .rd_ns  (rd_nonsec),
    .wr_hit (wr_viol),
    .wr_tag (wr_id),
    .wr_ns  (wr_nonsec),
    .any_hit(any_hit),
    .pick   (pick)
  );

  secviol_state u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (irq_clear),
    .any_hit(any_hit),
    .pick   (pick),
    .pending(irq_status),
    .held   (held)
  );

  assign info_word = pack_info(held);

  secviol_rdport u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rq_valid (rq_valid),
    .rq_ready (rq_ready),
    .rq_nonsec(rq_nonsec),
    .word     (info_word),
    .rs_valid (rs_valid),
    .rs_ready (rs_ready),
    .rs_data  (rs_data)
  );
endmodule

// File: rtl/secviol_capture_chk.sv
module secviol_capture_chk #(
  parameter int ID_W = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_viol,
  input logic        wr_viol,
  input logic        irq_clear,
  input logic        irq_status,
  input logic        rq_valid,
  input logic        rq_ready,
  input logic        rq_nonsec,
  input logic        rs_valid,
  input logic        rs_ready,
  input logic [31:0] rs_data,
  input logic [31:0] info_word
);
  localparam logic [31:0] RSV_MASK = 32'h7EEE_0000;
  localparam logic [31:0] ID_MASK  = (ID_W >= 16) ? 32'h0 : (32'h0000_FFFF & ~((32'h1 << ID_W) - 32'h1));

  a_r2_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_status && (rd_viol || wr_viol)) |=> irq_status);

  a_r4_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((info_word & (RSV_MASK | ID_MASK)) == 32'h0));

  a_r5_both_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    (info_word[20] |-> info_word[16]));

  a_r6_multi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status && !irq_clear && (rd_viol || wr_viol)) |=> info_word[24]);

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status && !irq_clear) |=> ($stable(info_word[31]) && $stable(info_word[20]) && $stable(info_word[16:0])));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !rd_viol && !wr_viol) |=> (!irq_status && info_word == 32'h0));

  a_r9_nonsec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready && rq_nonsec) |=> (rs_valid && rs_data == 32'h0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_data)));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |-> !rq_ready);
endmodule

bind secviol_capture secviol_capture_chk #(.ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_viol   (rd_viol),
  .wr_viol   (wr_viol),
  .irq_clear (irq_clear),
  .irq_status(irq_status),
  .rq_valid  (rq_valid),
  .rq_ready  (rq_ready),
  .rq_nonsec (rq_nonsec),
  .rs_valid  (rs_valid),
  .rs_ready  (rs_ready),
  .rs_data   (rs_data),
  .info_word (info_word)
);

// File: tb/secviol_capture_test.sv
`timescale 1ns/1ps
module secviol_capture_test;
  localparam int ID_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_viol = 0, wr_viol = 0, rd_nonsec = 0, wr_nonsec = 0, irq_clear = 0;
  logic [ID_W-1:0] rd_id = '0, wr_id = '0;
  logic irq_status, rq_valid = 0, rq_ready, rq_nonsec = 0, rs_valid, rs_ready = 1;
  logic [31:0] rs_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  secviol_capture #(.ID_W(ID_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_viol(rd_viol), .rd_id(rd_id), .rd_nonsec(rd_nonsec),
    .wr_viol(wr_viol), .wr_id(wr_id), .wr_nonsec(wr_nonsec),
    .irq_clear(irq_clear), .irq_status(irq_status),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_nonsec(rq_nonsec),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data)
  );

  function automatic logic [31:0] expect_word(bit ns, bit multi, bit both, bit wr, int id);
    logic [31:0] w;
    w = 32'(id) & 32'h0000_FFFF;
    if (ns)    w = w + 32'h8000_0000;
    if (multi) w = w + 32'h0100_0000;
    if (both)  w = w + 32'h0010_0000;
    if (wr)    w = w + 32'h0001_0000;
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of violation/clear stimulus, driven at negedge
  task automatic hit(bit rv, int rid, bit rns, bit wv, int wid, bit wns, bit clr);
    @(negedge clk);
    rd_viol = rv; rd_id = ID_W'(rid); rd_nonsec = rns;
    wr_viol = wv; wr_id = ID_W'(wid); wr_nonsec = wns;
    irq_clear = clr;
    @(negedge clk);
    rd_viol = 0; wr_viol = 0; irq_clear = 0;
  endtask

  task automatic read_word(bit ns, output logic [31:0] d);
    @(negedge clk);
    rq_valid = 1; rq_nonsec = ns; rs_ready = 1;
    @(negedge clk);
    rq_valid = 0;
    d = rs_valid ? rs_data : 32'hDEAD_BEEF;
  endtask

  task automatic clear_all();
    hit(0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq_status), 0);
    check("R1 rs_valid", 32'(rs_valid), 0);
    check("R1 rq_ready", 32'(rq_ready), 1);
    read_word(0, d); check("R1 word", d, 0);

    // R2/R3/R4 sweep over direction, protection and every ID
    for (int dir = 0; dir < 2; dir++)
      for (int ns = 0; ns < 2; ns++)
        for (int id = 0; id < (1 << ID_W); id++) begin
          if (dir == 0) hit(1, id, ns[0], 0, 0, 0, 0);
          else          hit(0, 0, 0, 1, id, ns[0], 0);
          check(dir ? "R3 irq" : "R2 irq", 32'(irq_status), 1);
          read_word(0, d);
          check(dir ? "R3/R4 word" : "R2/R4 word", d, expect_word(ns[0], 0, 0, dir[0], id));
          clear_all();
        end

    // R5 coincident violations, various sides
    for (int k = 0; k < 8; k++) begin
      hit(1, 8'h3C + k, k[0], 1, 8'hC1 + 3*k, k[1], 0);
      read_word(0, d);
      check("R5 both", d, expect_word(k[1], 0, 1, 1, (8'hC1 + 3*k) & 8'hFF));
      clear_all();
    end

    // R6 further violations freeze and set multi; R6 multi stays 0 without them
    hit(1, 8'h5A, 1, 0, 0, 0, 0);
    read_word(0, d); check("R6 no multi", d, expect_word(1, 0, 0, 0, 8'h5A));
    hit(0, 0, 0, 1, 8'h11, 0, 0);
    read_word(0, d); check("R6 multi", d, expect_word(1, 1, 0, 0, 8'h5A));
    hit(1, 8'h22, 0, 1, 8'h33, 1, 0);
    read_word(0, d); check("R6 frozen", d, expect_word(1, 1, 0, 0, 8'h5A));
    check("R6 irq", 32'(irq_status), 1);

    // R7 clear
    clear_all();
    check("R7 irq", 32'(irq_status), 0);
    read_word(0, d); check("R7 word", d, 0);

    // R8 clear with simultaneous violation while pending
    hit(1, 8'h01, 0, 0, 0, 0, 0);
    hit(1, 8'h02, 0, 0, 0, 0, 0);
    hit(0, 0, 0, 1, 8'h7E, 1, 1);
    check("R8 irq", 32'(irq_status), 1);
    read_word(0, d); check("R8 recapture", d, expect_word(1, 0, 0, 1, 8'h7E));

    // R9 non-secure read gives zero and leaves state alone
    read_word(1, d); check("R9 nonsec", d, 0);
    read_word(0, d); check("R9 after nonsec", d, expect_word(1, 0, 0, 1, 8'h7E));
    check("R9 irq", 32'(irq_status), 1);

    // R10 back-pressure
    @(negedge clk);
    rs_ready = 0; rq_valid = 1; rq_nonsec = 0;
    @(negedge clk);
    rq_valid = 0;
    check("R10 valid", 32'(rs_valid), 1);
    check("R10 ready low", 32'(rq_ready), 0);
    hit(1, 8'h44, 0, 0, 0, 0, 1);
    check("R10 hold valid", 32'(rs_valid), 1);
    check("R10 hold data", rs_data, expect_word(1, 0, 0, 1, 8'h7E));
    @(negedge clk);
    rs_ready = 1;
    @(negedge clk);
    check("R10 drained", 32'(rs_valid), 0);
    read_word(0, d); check("R10 next", d, expect_word(0, 0, 0, 0, 8'h44));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule